// File: doc/BRIEF.md
# External Bus Idle-Gap Sequencer

This block runs read cycles on an external bus divided into several chip-select areas. Each read passes through four phases in a fixed order: an address setup phase (T1), a strobe phase (T2), a pulse-width phase (Tpw) and a hold phase (T3). Between two reads that target different areas, the block keeps the bus quiet for at least a programmable number of cycles. This gives the slower device in the previous area time to release the data lines.

Cycles in which the core makes no external request are external NOP cycles. The block counts them toward the required gap. When a new request arrives for a different area, the block inserts only the cycles still missing, as idle phases (Ti), before the next T1. A pending request waits through those idle phases. Requests use a valid/ready handshake. The gap setting is a 3-bit value and is expected to stay stable while accesses are in flight.

Top module: `ext_idle_inserter`

## Requirements
- R1: While and after reset, with no request, phase_o is 0 (NOP), cs_o is all zero, rd_o is 0, busy_o is 0 and req_ready is 1.
- R2: A request accepted during a NOP cycle, with no idle shortfall, produces phase T1 (code 1) in the next cycle, then T2 (2), Tpw (3) and T3 (4) in consecutive cycles.
- R3: cs_o bit `area` is high in T1, T2, Tpw and T3 of an access to that area, and every other bit stays low. In NOP (0) and Ti (5) phases cs_o is all zero.
- R4: rd_o is high exactly in the T2 and Tpw phases.
- R5: req_ready is high only in the NOP and T3 phases. busy_o is high in every phase except NOP.
- R6: When a request to a different area is accepted in T3, exactly `idle_cfg` Ti phases separate that T3 from the next T1.
- R7: When k NOP cycles follow T3 (the accepting cycle counts as one) before a request to a different area, max(idle_cfg − k, 0) Ti phases are inserted.
- R8: Consecutive reads to the same area have no Ti phase between them, whatever the NOP count.
- R9: An idle_cfg of 0 inserts no Ti phase.
- R10: The first access after reset starts T1 without any Ti phase.
- R11: addr_o carries the accepted address from T1 through T3 of its access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request is accepted at this edge when valid |
| req_addr | input | ADDR_W | Read address |
| req_area | input | AREA_W | Target area number |
| idle_cfg | input | 3 | Minimum quiet cycles between reads to different areas |
| cs_o | output | NUM_AREAS | Per-area chip selects, active high |
| rd_o | output | 1 | Read strobe, active high |
| addr_o | output | ADDR_W | External address |
| phase_o | output | 3 | Bus phase: 0 NOP, 1 T1, 2 T2, 3 Tpw, 4 T3, 5 Ti |
| busy_o | output | 1 | An access or an idle insertion is in progress |

## Verification
Every output is decoded from registers. A handshake at one rising edge therefore shows up as T1 or Ti at that same edge, and each later phase advances by exactly one cycle. The bench drives inputs and samples outputs at falling edges, so each value it reads is the one set by the preceding rising edge. Gaps are measured by counting the NOP and Ti phases seen between one T3 and the next T1. The expected idle count is computed from the setting, the NOP count and whether the area changes.

// File: rtl/bic_pkg.sv
package bic_pkg;

    localparam int IDLE_W = 3;

    typedef enum logic [2:0] {
        PH_NOP = 3'd0,
        PH_T1  = 3'd1,
        PH_T2  = 3'd2,
        PH_TPW = 3'd3,
        PH_T3  = 3'd4,
        PH_TI  = 3'd5
    } bus_phase_e;

    // True when the quiet cycles seen so far, counting the current one, reach the setting
    function automatic logic gap_reached(input logic [IDLE_W-1:0] gap,
                                         input logic [IDLE_W-1:0] cfg);
        return ({1'b0, gap} + 1'b1) >= {1'b0, cfg};
    endfunction

    function automatic logic is_access(input bus_phase_e ph);
        return (ph == PH_T1) || (ph == PH_T2) || (ph == PH_TPW) || (ph == PH_T3);
    endfunction

    function automatic logic is_strobe(input bus_phase_e ph);
        return (ph == PH_T2) || (ph == PH_TPW);
    endfunction

endpackage

// File: rtl/bic_gap_counter.sv
module bic_gap_counter
    import bic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              count_en,
    input  logic [IDLE_W-1:0] cfg,
    output logic [IDLE_W-1:0] gap_o,
    output logic              met_o
);

    logic [IDLE_W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            gap_q <= '0;
        end else if (count_en && (gap_q < cfg)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assign gap_o = gap_q;
    assign met_o = gap_reached(gap_q, cfg);

endmodule

// File: rtl/bic_seq.sv
module bic_seq
    import bic_pkg::*;
#(
    parameter int AREA_W = 2,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [AREA_W-1:0] req_area,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [IDLE_W-1:0] cfg,
    input  logic              gap_met,
    output bus_phase_e        phase_o,
    output logic [AREA_W-1:0] area_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              ready_o
);

    bus_phase_e        phase_q, phase_d;
    logic [AREA_W-1:0] area_q;
    logic [ADDR_W-1:0] addr_q;
    logic              seen_q;
    logic              accept;
    logic              area_change;
    logic              need_idle;

    assign ready_o     = (phase_q == PH_NOP) || (phase_q == PH_T3);
    assign accept      = ready_o && req_valid;
    assign area_change = seen_q && (req_area != area_q);

    // Shortfall check: at T3 no quiet cycle has elapsed yet; in NOP the counter knows
    always_comb begin
        if (phase_q == PH_T3) begin
            need_idle = area_change && (cfg != '0);
        end else begin
            need_idle = area_change && !gap_met;
        end
    end

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_NOP:  if (accept) phase_d = need_idle ? PH_TI : PH_T1;
            PH_T1:   phase_d = PH_T2;
            PH_T2:   phase_d = PH_TPW;
            PH_TPW:  phase_d = PH_T3;
            PH_T3:   phase_d = accept ? (need_idle ? PH_TI : PH_T1) : PH_NOP;
            PH_TI:   if (gap_met) phase_d = PH_T1;
            default: phase_d = PH_NOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_NOP;
            area_q  <= '0;
            addr_q  <= '0;
            seen_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            if (accept) begin
                area_q <= req_area;
                addr_q <= req_addr;
                seen_q <= 1'b1;
            end
        end
    end

    assign phase_o = phase_q;
    assign area_o  = area_q;
    assign addr_o  = addr_q;

endmodule

// File: rtl/bic_strobe_dec.sv
module bic_strobe_dec
    import bic_pkg::*;
#(
    parameter int NUM_AREAS = 4,
    parameter int AREA_W    = 2
) (
    input  bus_phase_e           phase,
    input  logic [AREA_W-1:0]    area,
    output logic [NUM_AREAS-1:0] cs,
    output logic                 rd,
    output logic                 busy
);

    logic active;
    assign active = is_access(phase);

    for (genvar g = 0; g < NUM_AREAS; g++) begin : g_cs
        assign cs[g] = active && (area == AREA_W'(g));
    end

    assign rd   = is_strobe(phase);
    assign busy = (phase != PH_NOP);

endmodule

// File: rtl/ext_idle_inserter.sv
module ext_idle_inserter
    import bic_pkg::*;
#(
    parameter  int NUM_AREAS = 4,
    parameter  int ADDR_W    = 16,
    localparam int AREA_W    = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [AREA_W-1:0]    req_area,
    input  logic [IDLE_W-1:0]    idle_cfg,
    output logic [NUM_AREAS-1:0] cs_o,
    output logic                 rd_o,
    output logic [ADDR_W-1:0]    addr_o,
    output logic [2:0]           phase_o,
    output logic                 busy_o
);

    bus_phase_e        phase;
    logic [AREA_W-1:0] cur_area;
    logic [IDLE_W-1:0] gap_cnt;
    logic              gap_met;

    bic_seq #(.AREA_W(AREA_W), .ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_area  (req_area),
        .req_addr  (req_addr),
        .cfg       (idle_cfg),
        .gap_met   (gap_met),
        .phase_o   (phase),
        .area_o    (cur_area),
        .addr_o    (addr_o),
        .ready_o   (req_ready)
    );

    bic_gap_counter u_gap (
        .clk      (clk),
        .rst      (rst),
        .clear    (phase == PH_T3),
        .count_en ((phase == PH_NOP) || (phase == PH_TI)),
        .cfg      (idle_cfg),
        .gap_o    (gap_cnt),
        .met_o    (gap_met)
    );

    bic_strobe_dec #(.NUM_AREAS(NUM_AREAS), .AREA_W(AREA_W)) u_dec (
        .phase (phase),
        .area  (cur_area),
        .cs    (cs_o),
        .rd    (rd_o),
        .busy  (busy_o)
    );

    assign phase_o = phase;

    logic unused_gap;
    assign unused_gap = ^gap_cnt;

endmodule

// File: rtl/ext_idle_inserter_chk.sv
module ext_idle_inserter_chk
    import bic_pkg::*;
#(
    parameter int NUM_AREAS = 4,
    parameter int ADDR_W    = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic [2:0]           phase_o,
    input logic [NUM_AREAS-1:0] cs_o,
    input logic                 req_ready,
    input logic [ADDR_W-1:0]    addr_o,
    input logic [IDLE_W-1:0]    idle_cfg
);

    AST_T1_THEN_T2: assert property (@(posedge clk) disable iff (rst)
        phase_o == PH_T1 |=> phase_o == PH_T2); // R2
    AST_T2_THEN_TPW: assert property (@(posedge clk) disable iff (rst)
        phase_o == PH_T2 |=> phase_o == PH_TPW); // R2
    AST_TPW_THEN_T3: assert property (@(posedge clk) disable iff (rst)
        phase_o == PH_TPW |=> phase_o == PH_T3); // R2
    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cs_o)); // R3
    AST_CS_HELD: assert property (@(posedge clk) disable iff (rst)
        (phase_o == PH_T2 || phase_o == PH_TPW || phase_o == PH_T3) |-> $stable(cs_o)); // R3
    AST_READY_WINDOW: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (phase_o == PH_NOP || phase_o == PH_T3)); // R5
    AST_ZERO_CFG_NO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (idle_cfg == '0 && $past(idle_cfg) == '0) |-> phase_o != PH_TI); // R9
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (phase_o == PH_T2 || phase_o == PH_TPW || phase_o == PH_T3) |-> $stable(addr_o)); // R11

endmodule

bind ext_idle_inserter ext_idle_inserter_chk #(.NUM_AREAS(NUM_AREAS), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .phase_o   (phase_o),
    .cs_o      (cs_o),
    .req_ready (req_ready),
    .addr_o    (addr_o),
    .idle_cfg  (idle_cfg)
);

// File: tb/ext_idle_inserter_tb_top.sv
module ext_idle_inserter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NA  = 4;
    localparam int AW  = 16;
    localparam int ARW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [ARW-1:0] req_area = '0;
    logic [2:0]    idle_cfg = 3'd4;
    logic [NA-1:0] cs_o;
    logic          rd_o;
    logic [AW-1:0] addr_o;
    logic [2:0]    phase_o;
    logic          busy_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_idle_inserter #(.NUM_AREAS(NA), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_area(req_area), .idle_cfg(idle_cfg),
        .cs_o(cs_o), .rd_o(rd_o), .addr_o(addr_o), .phase_o(phase_o), .busy_o(busy_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            finish_run();
        end
    end

    // Expects phase T1 at the current falling edge; ends at the T3 falling edge
    task automatic watch_access(input int area, input int addr);
        for (int p = 1; p <= 4; p++) begin
            check(phase_o == 3'(p), "R2 phase order", phase_o, p);
            check(cs_o == NA'(1 << area), "R3 chip select", cs_o, 1 << area);
            check(rd_o == (p == 2 || p == 3), "R4 read strobe", rd_o, (p == 2 || p == 3));
            check(addr_o == AW'(addr), "R11 address", addr_o, addr);
            check(busy_o == 1'b1, "R5 busy", busy_o, 1);
            check(req_ready == (p == 4), "R5 ready", req_ready, (p == 4));
            if (p < 4) @(negedge clk);
        end
    endtask

    task automatic run_pair(input int cfg, input int a1, input int a2, input int k, input string tag);
        int exp_ti;
        int ti;
        idle_cfg = 3'(cfg);
        repeat (9) @(negedge clk);
        req_valid = 1'b1; req_area = ARW'(a1); req_addr = AW'(16'h1000 + a1);
        @(negedge clk);
        req_valid = 1'b0;
        watch_access(a1, 16'h1000 + a1);
        for (int n = 0; n < k; n++) begin
            @(negedge clk);
            check(phase_o == 3'd0 && cs_o == '0 && !busy_o, {tag, " NOP"}, phase_o, 0);
        end
        req_valid = 1'b1; req_area = ARW'(a2); req_addr = AW'(16'h2000 + a2);
        @(negedge clk);
        req_valid = 1'b0;
        exp_ti = (a1 != a2 && cfg > k) ? cfg - k : 0;
        ti = 0;
        while (phase_o == 3'd5 && ti < 20) begin
            check(cs_o == '0 && !rd_o && busy_o && !req_ready, "R3 R5 idle outputs", cs_o, 0);
            ti++;
            @(negedge clk);
        end
        check(ti == exp_ti, tag, ti, exp_ti);
        watch_access(a2, 16'h2000 + a2);
        @(negedge clk);
        check(phase_o == 3'd0, "R2 return to NOP", phase_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(phase_o == 3'd0 && cs_o == '0 && !rd_o && !busy_o && req_ready, "R1 in reset", phase_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check(phase_o == 3'd0 && cs_o == '0 && !rd_o && !busy_o && req_ready, "R1 after reset", phase_o, 0);
        // R10: first access after reset goes straight to T1
        idle_cfg = 3'd4;
        req_valid = 1'b1; req_area = 2'd2; req_addr = 16'h0abc;
        @(negedge clk);
        req_valid = 1'b0;
        check(phase_o == 3'd1, "R10 first access no idle", phase_o, 1);
        watch_access(2, 16'h0abc);
        run_pair(4, 0, 1, 0, "R6 back-to-back idle count");
        run_pair(7, 1, 3, 0, "R6 max idle count");
        run_pair(1, 2, 0, 0, "R6 single idle");
        run_pair(4, 0, 2, 2, "R7 partial NOP credit");
        run_pair(4, 3, 1, 1, "R7 one NOP credited");
        run_pair(4, 1, 2, 4, "R7 NOPs cover gap");
        run_pair(4, 2, 3, 6, "R7 NOPs exceed gap");
        run_pair(4, 1, 1, 0, "R8 same area");
        run_pair(7, 3, 3, 2, "R8 same area with NOPs");
        run_pair(0, 0, 3, 0, "R9 zero setting");
        finish_run();
    end

endmodule